// File: doc/BRIEF.md
# Port-Mapped Peripheral I/O Bridge

This block sits between the port-style I/O bus of a small 8-bit soft microcontroller and the peripherals it services: the push side of a serial transmit byte FIFO, the pop side of a serial receive byte FIFO, an 8-bit general-purpose input and an 8-bit general-purpose output register. It decodes the 8-bit port address. It captures output data when the write strobe is high. It places the selected read data on the input bus and pops a received byte when the processor takes it.

The processor runs two-cycle I/O instructions, and its strobes come in the second cycle. For that reason the read data is driven combinationally from the address in every cycle. An interrupt request is raised when the receive FIFO goes from empty to non-empty while the enable bit is set. The request stays high until the processor acknowledges it, so the two-clock minimum width of the request is always met.

The serial bit engines and the FIFOs themselves lie outside the block. The serial frame is 1 start bit, 8 data bits and 1 stop bit, and each direction has 16 byte entries. The bridge sees only the FIFO flags and data.

Top module: `pio_bridge`

## Requirements
- R1: While `rst_n` is low at a rising edge, the output register, the interrupt enable register and the sticky overflow flag all clear to 0, and `irq` goes low.
- R2: A write strobe with port address 0x04 loads `out_data` into the output register, which drives `gpio_out`. A read of port 0x04 returns that value.
- R3: `in_data` follows `port_addr` combinationally in every cycle, so it is already valid in the cycle before the read strobe. Port 0x03 returns `gpio_in`, port 0x05 returns the interrupt enable register, and any address above 0x05 returns 0x00.
- R4: A write strobe with port address 0x02 while `tx_full` is low asserts `tx_push` for exactly that cycle, with `tx_wdata` equal to `out_data`. Bytes therefore enter the transmit FIFO in write order.
- R5: A read of port 0x01 returns status: bit0 receive FIFO non-empty, bit1 transmit FIFO full, bit2 transmit FIFO half full, bit7 sticky overflow. Bits 6..3 read as 0.
- R6: A write to port 0x02 while `tx_full` is high is dropped and sets the sticky overflow flag. A read strobe on port 0x01 clears the flag after returning it. A new overflow in the same cycle takes priority over the clear.
- R7: A read of port 0x00 returns the head of the receive FIFO and asserts `rx_pop` for the strobe cycle. If the FIFO is empty, the read returns 0x00 and `rx_pop` stays low.
- R8: When `rx_valid` rises and bit0 of the interrupt enable register (port 0x05) is set, `irq` goes high one clock later. With bit0 clear, no request is raised.
- R9: Once high, `irq` stays high until a cycle in which `irq_ack` is high. It is low from the following edge on.
- R10: Writes to ports other than 0x02, 0x04 and 0x05 change no register and push nothing. Reads of ports other than 0x00 never pop the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| port_addr | input | 8 | I/O port address from the processor |
| out_data | input | 8 | Data from the processor for output instructions |
| wr_stb | input | 1 | Write strobe, second cycle of an output instruction |
| rd_stb | input | 1 | Read strobe, second cycle of an input instruction |
| in_data | output | 8 | Data to the processor for input instructions |
| irq | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| tx_push | output | 1 | Push one byte into the transmit FIFO |
| tx_wdata | output | 8 | Byte pushed into the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| tx_half | input | 1 | Transmit FIFO at least half full |
| rx_valid | input | 1 | Receive FIFO non-empty |
| rx_rdata | input | 8 | Byte at the head of the receive FIFO |
| rx_pop | output | 1 | Pop the head of the receive FIFO |
| gpio_in | input | 8 | General-purpose input from the attached device |
| gpio_out | output | 8 | General-purpose output register |

## Verification
The hardest state to reach from the ports is the sticky overflow flag. It needs the transmit FIFO model to reach 16 entries with nothing draining it, and then one further write. The stimulus fills the FIFO through sixteen normal port writes, checks the full and half-full status on the way, and issues the extra write. It then reads status twice to see the flag first returned and then cleared. The interrupt path also needs a rising edge of receive non-empty with the enable bit already set. So the receive FIFO is emptied by reads before a fresh byte is injected, and the request is held across several idle cycles before the acknowledge is given.

// File: rtl/pio_bridge_pkg.sv
// Package: port numbers and status bit positions shared by the bridge modules.
// Assumes ports are numbered consecutively from zero.
package pio_bridge_pkg;
    localparam int NUM_PORTS  = 6;
    localparam int P_RXDATA   = 0;
    localparam int P_STATUS   = 1;
    localparam int P_TXDATA   = 2;
    localparam int P_GPIN     = 3;
    localparam int P_GPOUT    = 4;
    localparam int P_IRQEN    = 5;
    localparam int ST_RXNE    = 0;
    localparam int ST_TXFULL  = 1;
    localparam int ST_TXHALF  = 2;
    localparam int ST_OVF     = 7;
endpackage

// File: rtl/pio_addr_decode.sv
// Address decoder: one select line per mapped port, qualified by each strobe.
// Assumes port_addr is stable while a strobe is high.
module pio_addr_decode
    import pio_bridge_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]    port_addr,
    input  logic                 wr_stb,
    input  logic                 rd_stb,
    output logic [NUM_PORTS-1:0] sel,
    output logic [NUM_PORTS-1:0] wr_sel,
    output logic [NUM_PORTS-1:0] rd_sel
);
    // One comparator per mapped port.
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        assign sel[i]    = (port_addr == ADDR_W'(i));
        assign wr_sel[i] = sel[i] & wr_stb;
        assign rd_sel[i] = sel[i] & rd_stb;
    end
endmodule

// File: rtl/pio_ctrl_regs.sv
// Control registers: output register, interrupt enable, sticky overflow and transmit push.
// Assumes wr_sel/rd_sel are single-cycle strobes from the decoder.
module pio_ctrl_regs
    import pio_bridge_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] wr_sel,
    input  logic [NUM_PORTS-1:0] rd_sel,
    input  logic [DATA_W-1:0]    out_data,
    input  logic                 tx_full,
    output logic                 tx_push,
    output logic [DATA_W-1:0]    tx_wdata,
    output logic [DATA_W-1:0]    gpio_out,
    output logic [DATA_W-1:0]    irq_en,
    output logic                 ovf
);
    // Transmit push: only when the FIFO has room.
    assign tx_push  = wr_sel[P_TXDATA] & ~tx_full;
    assign tx_wdata = out_data;

    // Output register and interrupt enable register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_out <= '0;
            irq_en   <= '0;
        end else begin
            if (wr_sel[P_GPOUT]) gpio_out <= out_data;
            if (wr_sel[P_IRQEN]) irq_en   <= out_data;
        end
    end

    // Sticky overflow: set on dropped write, cleared by status read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ovf <= 1'b0;
        else if (wr_sel[P_TXDATA] && tx_full)  ovf <= 1'b1;
        else if (rd_sel[P_STATUS])             ovf <= 1'b0;
    end

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[P_TXDATA] && tx_full) |=> ovf);
    p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !rd_sel[P_STATUS]) |=> ovf);
    p_gpio_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[P_GPOUT] |=> $stable(gpio_out));
    p_irqen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[P_IRQEN] |=> $stable(irq_en));
endmodule

// File: rtl/pio_irq_ctrl.sv
// Interrupt controller: raises irq on a rising receive non-empty flag when enabled,
// holds it until acknowledged. Assumes irq_ack is a single-cycle pulse.
module pio_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic enable,
    input  logic irq_ack,
    output logic irq
);
    logic rx_prev;
    logic set_ev;

    assign set_ev = rx_valid & ~rx_prev & enable;

    // Edge detector history for the receive non-empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_prev <= 1'b0;
        else        rx_prev <= rx_valid;
    end

    // Request register: a new event wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (set_ev)  irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
    p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(enable));
endmodule

// File: rtl/pio_read_mux.sv
// Read path: selects input data from the address every cycle and pops the receive FIFO.
// Assumes rx_rdata is valid whenever rx_valid is high.
module pio_read_mux
    import pio_bridge_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NUM_PORTS-1:0] sel,
    input  logic [NUM_PORTS-1:0] rd_sel,
    input  logic                 rx_valid,
    input  logic [DATA_W-1:0]    rx_rdata,
    input  logic [DATA_W-1:0]    status,
    input  logic [DATA_W-1:0]    gpio_in,
    input  logic [DATA_W-1:0]    gpio_out,
    input  logic [DATA_W-1:0]    irq_en,
    output logic [DATA_W-1:0]    in_data,
    output logic                 rx_pop
);
    // Pop only when a byte is present.
    assign rx_pop = rd_sel[P_RXDATA] & rx_valid;

    // Combinational data select; unmapped ports read zero.
    always_comb begin
        in_data = '0;
        if (sel[P_RXDATA] && rx_valid) in_data = rx_rdata;
        if (sel[P_STATUS])             in_data = status;
        if (sel[P_GPIN])               in_data = gpio_in;
        if (sel[P_GPOUT])              in_data = gpio_out;
        if (sel[P_IRQEN])              in_data = irq_en;
    end
endmodule

// File: rtl/pio_bridge.sv
// Top: connects the processor I/O bus to transmit/receive FIFO endpoints and GPIO.
// Assumes strobes come in the second cycle of two-cycle I/O instructions.
module pio_bridge
    import pio_bridge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] out_data,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] in_data,
    output logic              irq,
    input  logic              irq_ack,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_full,
    input  logic              tx_half,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_rdata,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] gpio_in,
    output logic [DATA_W-1:0] gpio_out
);
    logic [NUM_PORTS-1:0] sel, wr_sel, rd_sel;
    logic [DATA_W-1:0]    irq_en;
    logic [DATA_W-1:0]    status;
    logic                 ovf;

    // Status word assembly.
    always_comb begin
        status            = '0;
        status[ST_RXNE]   = rx_valid;
        status[ST_TXFULL] = tx_full;
        status[ST_TXHALF] = tx_half;
        status[ST_OVF]    = ovf;
    end

    pio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .port_addr(port_addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .sel(sel), .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    pio_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .rd_sel(rd_sel),
        .out_data(out_data), .tx_full(tx_full), .tx_push(tx_push),
        .tx_wdata(tx_wdata), .gpio_out(gpio_out), .irq_en(irq_en), .ovf(ovf)
    );

    pio_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
        .enable(irq_en[0]), .irq_ack(irq_ack), .irq(irq)
    );

    pio_read_mux #(.DATA_W(DATA_W)) u_rd (
        .sel(sel), .rd_sel(rd_sel), .rx_valid(rx_valid), .rx_rdata(rx_rdata),
        .status(status), .gpio_in(gpio_in), .gpio_out(gpio_out), .irq_en(irq_en),
        .in_data(in_data), .rx_pop(rx_pop)
    );

    p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && port_addr == ADDR_W'(P_RXDATA) && !rx_valid) |-> (in_data == '0 && !rx_pop));
    p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (wr_stb && !tx_full));
    p_pop_only_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rd_stb && port_addr == ADDR_W'(P_RXDATA)));
endmodule

// File: tb/tb_pio_bridge.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares on each read strobe.
module tb_pio_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_addr = '0, out_data = '0, gpio_in = '0;
    logic       wr_stb = 1'b0, rd_stb = 1'b0, irq_ack = 1'b0;
    logic       tx_full = 1'b0, tx_half = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_rdata = '0;
    logic [7:0] in_data, tx_wdata, gpio_out;
    logic       irq, tx_push, rx_pop;

    int n_tests = 0, n_fail = 0, pops = 0;
    bit done = 0;
    logic [7:0] tx_q[$], tx_log[$], rx_q[$], inj_q[$], exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pio_bridge dut (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .out_data(out_data),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .in_data(in_data), .irq(irq),
        .irq_ack(irq_ack), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .tx_half(tx_half), .rx_valid(rx_valid),
        .rx_rdata(rx_rdata), .rx_pop(rx_pop), .gpio_in(gpio_in), .gpio_out(gpio_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // FIFO endpoint models (16 entries each).
    always @(posedge clk) begin
        if (tx_push && tx_q.size() < 16) begin
            tx_q.push_back(tx_wdata);
            tx_log.push_back(tx_wdata);
        end
        if (rx_pop && rx_q.size() > 0) begin
            void'(rx_q.pop_front());
            pops++;
        end
        while (inj_q.size() > 0) rx_q.push_back(inj_q.pop_front());
        tx_full  <= (tx_q.size() == 16);
        tx_half  <= (tx_q.size() >= 8);
        rx_valid <= (rx_q.size() != 0);
        rx_rdata <= (rx_q.size() != 0) ? rx_q[0] : 8'h00;
    end

    // Monitor: compare read data on each read strobe.
    always @(negedge clk) begin
        if (rd_stb && exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(in_data === e, t, in_data, e);
        end
    end

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1 port_addr = a; out_data = d;
        @(posedge clk); #1 wr_stb = 1'b1;
        @(posedge clk); #1 wr_stb = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1 port_addr = a;
        @(negedge clk);
        check(in_data === e, {tag, " R3 first cycle"}, in_data, e);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1 rd_stb = 1'b1;
        @(posedge clk); #1 rd_stb = 1'b0;
    endtask

    task automatic inject(input logic [7:0] b);
        @(posedge clk); #1 inj_q.push_back(b);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(gpio_out === 8'h00, "R1 gpio_out reset", gpio_out, 0);
        check(irq === 1'b0, "R1 irq reset", irq, 0);
        io_read(8'h05, 8'h00, "R1 irq enable reset");
        io_read(8'h01, 8'h00, "R1 status reset");

        io_write(8'h04, 8'h5A);
        @(negedge clk);
        check(gpio_out === 8'h5A, "R2 gpio_out", gpio_out, 8'h5A);
        io_read(8'h04, 8'h5A, "R2 readback");
        gpio_in = 8'hC3;
        io_read(8'h03, 8'hC3, "R3 gpio_in");
        io_read(8'h06, 8'h00, "R3 unmapped");

        // R8: enable clear, no interrupt.
        inject(8'hA1); inject(8'hA2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(irq === 1'b0, "R8 masked no irq", irq, 0);
        io_read(8'h01, 8'h01, "R5 status rx non-empty");
        p0 = pops;
        io_write(8'h00, 8'h99); io_write(8'h03, 8'h99);
        io_read(8'h01, 8'h01, "R10 status read no pop");
        check(pops == p0, "R10 no pop", pops, p0);
        check(tx_log.size() == 0, "R10 no push", tx_log.size(), 0);
        @(negedge clk);
        check(gpio_out === 8'h5A, "R10 gpio unchanged", gpio_out, 8'h5A);
        io_read(8'h00, 8'hA1, "R7 rx head 1");
        io_read(8'h00, 8'hA2, "R7 rx head 2");
        p0 = pops;
        io_read(8'h00, 8'h00, "R7 empty read");
        check(pops == p0, "R7 empty no pop", pops, p0);

        // R8/R9: enabled interrupt held until ack.
        io_write(8'h05, 8'h01);
        io_read(8'h05, 8'h01, "R3 irq enable readback");
        inject(8'h77);
        @(posedge clk); #1;
        check(irq === 1'b1, "R8 irq raised", irq, 1);
        repeat (4) @(posedge clk);
        #1 check(irq === 1'b1, "R9 irq held", irq, 1);
        irq_ack = 1'b1;
        @(posedge clk); #1 irq_ack = 1'b0;
        check(irq === 1'b0, "R9 irq cleared", irq, 0);
        io_read(8'h00, 8'h77, "R7 rx head 3");

        // R4/R5/R6: fill transmit FIFO, then overflow.
        for (int i = 0; i < 16; i++) begin
            io_write(8'h02, 8'(8'h10 + i));
            if (i == 7) io_read(8'h01, 8'h04, "R5 half full");
        end
        io_read(8'h01, 8'h06, "R5 full and half");
        io_write(8'h02, 8'hEE);
        check(tx_log.size() == 16, "R6 dropped write", tx_log.size(), 16);
        for (int i = 0; i < 16; i++)
            check(tx_log[i] === 8'(8'h10 + i), "R4 push order", tx_log[i], 8'h10 + i);
        io_read(8'h01, 8'h86, "R6 overflow set");
        io_read(8'h01, 8'h06, "R6 overflow cleared");

        repeat (2) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule